// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. It contains a programmable initial-value register and a down-counter. The counter steps down once for each pulse of a periodic tick enable. In a typical system the tick period is 0.6 s. Software keeps the system alive by writing to the reload register, which puts the counter back to the initial value. A halt bit freezes the counter.

If software stops reloading, the counter reaches zero and expires. The first expiry sets a first-timeout status flag, emits a one-cycle event pulse and reloads the counter automatically. If the counter expires again while that flag is still set, the block sets a second-timeout flag and raises a system-reset request. A no-reboot control bit vetoes the request. Clearing the first-timeout flag between expiries starts the two-expiry sequence over.

Top module: `wdt2_top`

## Requirements
- R1: After reset the halt bit reads 1, the no-reboot bit reads 1, the initial value reads 0x004, the counter reads 0x004, both timeout flags read 0, and the reset request is low.
- R2: The initial-value register is at address 1. Its value is bits [9:0]. Any value from 4 to 0x3FF written there is stored and reads back next cycle. Bits [15:10] always read 0, and the data written to them has no effect.
- R3: A write of 0 to 3 into bits [9:0] at address 1 is ignored, and the previously stored initial value reads back unchanged.
- R4: A write of any value to address 0 loads the counter with the initial value. A read of address 0 returns the counter in bits [9:0]. Read data is valid in the same cycle as rd_en_i, and is zero when rd_en_i is low.
- R5: Bit 11 of the control register at address 4 is the halt bit. While it is 1 the counter holds its value. While it is 0 the counter decrements by one on each tick.
- R6: A tick that finds the running counter at zero is an expiry. The expiry reloads the counter with the initial value. If the first-timeout flag is clear, the expiry sets that flag (bit 3 at address 2) and pulses irq_o high for exactly one cycle.
- R7: Writing 1 to bit 3 at address 2 clears the first-timeout flag. Writing 0 there leaves it set. After it is cleared, the next expiry counts as a first expiry again.
- R8: An expiry while the first-timeout flag is set sets the second-timeout flag (bit 1 at address 3) and raises rst_req_o, unless no-reboot is set. Writing 1 to bit 1 at address 3 clears the flag and drops rst_req_o.
- R9: The no-reboot bit is bit 0 of the control register at address 5. While it is 1, rst_req_o stays low even when a second expiry occurs, although the second-timeout flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic count enable, one cycle per tick |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | One-cycle first-expiry event |
| rst_req_o | output | 1 | System-reset request |

## Verification
Reads are combinational, so the bench compares read data in the same cycle as the strobe, at the falling edge. A register write, a reload or a tick takes effect at the next rising edge. So the bench reads back starting in the cycle that follows the write. An expiry happens at the rising edge that samples the zero count, and irq_o and rst_req_o are registered. The bench therefore compares these outputs at the falling edge of the cycle right after the final tick. irq_o is checked again one cycle later to confirm that it has already dropped.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 3;
    localparam int HALT_BIT     = 11;
    localparam int FIRST_BIT    = 3;
    localparam int SECOND_BIT   = 1;
    localparam int NOREBOOT_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT = 3'd0,
        REG_INIT  = 3'd1,
        REG_STAT1 = 3'd2,
        REG_STAT2 = 3'd3,
        REG_CTRL1 = 3'd4,
        REG_CTRL2 = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/wdt2_countdown.sv
module wdt2_countdown #(
    parameter int CNT_W   = 10,
    parameter int RST_VAL = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             force_i,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (force_i) begin
            st_d.count = init_i;
        end else if (run_i && tick_i) begin
            if (st_q.count == '0) begin
                expire_d   = 1'b1;
                st_d.count = init_i;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.count <= CNT_W'(RST_VAL);
        else         st_q       <= st_d;
    end

    assign count_o  = st_q.count;
    assign expire_o = expire_d;
endmodule

// File: rtl/wdt2_escalate.sv
module wdt2_escalate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic clr_first_i,
    input  logic clr_second_i,
    input  logic no_reboot_i,
    output logic first_o,
    output logic second_o,
    output logic irq_o,
    output logic rst_req_o
);
    typedef struct packed {
        logic first;
        logic second;
        logic irq;
        logic rst_req;
    } esc_state_t;

    esc_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (clr_first_i) st_d.first = 1'b0;
        if (clr_second_i) begin
            st_d.second  = 1'b0;
            st_d.rst_req = 1'b0;
        end
        if (expire_i) begin
            if (st_q.first) begin
                st_d.first   = 1'b1;
                st_d.second  = 1'b1;
                st_d.rst_req = 1'b1;
            end else begin
                st_d.first = 1'b1;
                st_d.irq   = 1'b1;
            end
        end
        if (no_reboot_i) st_d.rst_req = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign first_o   = st_q.first;
    assign second_o  = st_q.second;
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst_req;
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4,
    parameter int RST_INIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] init;
        logic             halt;
        logic             no_reboot;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             wr_reload, clr_first, clr_second;
    logic [CNT_W-1:0] count_w;
    logic             expire_w, first_w, second_w;
    logic [CNT_W-1:0] init_w;
    logic             halt_w, no_reboot_w;

    always_comb begin
        cfg_d      = cfg_q;
        wr_reload  = 1'b0;
        clr_first  = 1'b0;
        clr_second = 1'b0;
        if (wr_en_i) begin
            unique case (addr_i)
                REG_COUNT: wr_reload = 1'b1;
                REG_INIT: begin
                    if (wdata_i[CNT_W-1:0] >= CNT_W'(MIN_INIT))
                        cfg_d.init = wdata_i[CNT_W-1:0];
                end
                REG_STAT1: clr_first  = wdata_i[FIRST_BIT];
                REG_STAT2: clr_second = wdata_i[SECOND_BIT];
                REG_CTRL1: cfg_d.halt      = wdata_i[HALT_BIT];
                REG_CTRL2: cfg_d.no_reboot = wdata_i[NOREBOOT_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.init      <= CNT_W'(RST_INIT);
            cfg_q.halt      <= 1'b1;
            cfg_q.no_reboot <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign init_w      = cfg_q.init;
    assign halt_w      = cfg_q.halt;
    assign no_reboot_w = cfg_q.no_reboot;

    wdt2_countdown #(.CNT_W(CNT_W), .RST_VAL(RST_INIT)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .run_i    (!halt_w),
        .force_i  (wr_reload),
        .init_i   (init_w),
        .count_o  (count_w),
        .expire_o (expire_w)
    );

    wdt2_escalate u_esc (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .expire_i     (expire_w),
        .clr_first_i  (clr_first),
        .clr_second_i (clr_second),
        .no_reboot_i  (no_reboot_w),
        .first_o      (first_w),
        .second_o     (second_w),
        .irq_o        (irq_o),
        .rst_req_o    (rst_req_o)
    );

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                REG_COUNT: rdata_o[CNT_W-1:0]   = count_w;
                REG_INIT:  rdata_o[CNT_W-1:0]   = init_w;
                REG_STAT1: rdata_o[FIRST_BIT]    = first_w;
                REG_STAT2: rdata_o[SECOND_BIT]   = second_w;
                REG_CTRL1: rdata_o[HALT_BIT]     = halt_w;
                REG_CTRL2: rdata_o[NOREBOOT_BIT] = no_reboot_w;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wdt2_checker.sv
module wdt2_checker #(
    parameter int CNT_W    = 10,
    parameter int MIN_INIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init,
    input logic             halt,
    input logic             no_reboot,
    input logic             first,
    input logic             second,
    input logic             irq,
    input logic             rst_req
);
    logic reload_wr;
    assign reload_wr = wr_en && (addr == 3'd0);

    AST_INIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        init >= CNT_W'(MIN_INIT)); // R3

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> count == $past(init)); // R4

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !reload_wr |=> $stable(count)); // R5

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> first); // R6

    AST_RST_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> first && second); // R8

    AST_NOREBOOT_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        no_reboot |=> !rst_req); // R9
endmodule

bind wdt2_top wdt2_checker #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .wr_en     (wr_en_i),
    .addr      (addr_i),
    .count     (count_w),
    .init      (init_w),
    .halt      (halt_w),
    .no_reboot (no_reboot_w),
    .first     (first_w),
    .second    (second_w),
    .irq       (irq_o),
    .rst_req   (rst_req_o)
);

// File: tb/sim_wdt2_top.sv
module sim_wdt2_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_RDATA  = 0;
    localparam int SEL_IRQ    = 1;
    localparam int SEL_RST    = 2;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        irq, rst_req;

    int    checks = 0;
    int    errors = 0;
    logic  go = 1'b0;
    bit    done = 1'b0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt2_top u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wdata_i   (wdata),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .rst_req_o (rst_req)
    );

    // monitor: pops one expected item per checking cycle
    always @(negedge clk) begin
        if (go && !done) begin
            item_t       it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = (it.sel == SEL_RDATA) ? rdata :
                  (it.sel == SEL_IRQ)   ? {15'd0, irq} : {15'd0, rst_req};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=0x%04h expected=0x%04h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int sel, input logic [15:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        go = 1'b1;
        @(posedge clk); #1;
        go = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        expect_item(SEL_RDATA, exp, tag);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd(3'd0, 16'h0004, "R1 count");
        rd(3'd1, 16'h0004, "R1 init");
        rd(3'd4, 16'h0800, "R1 halt");
        rd(3'd5, 16'h0001, "R1 noreboot");
        rd(3'd2, 16'h0000, "R1 stat1");
        rd(3'd3, 16'h0000, "R1 stat2");
        expect_item(SEL_RST, 16'h0000, "R1 rst_req");
        // read strobe low gives zero
        addr = 3'd1;
        expect_item(SEL_RDATA, 16'h0000, "R4 idle rdata");

        // R5 halted counter holds
        ticks(3);
        rd(3'd0, 16'h0004, "R5 halted hold");

        // R2 / R3 initial value
        wr(3'd1, 16'h000A);
        rd(3'd1, 16'h000A, "R2 init write");
        wr(3'd1, 16'h0003);
        rd(3'd1, 16'h000A, "R3 init 3 ignored");
        wr(3'd1, 16'h0000);
        rd(3'd1, 16'h000A, "R3 init 0 ignored");
        wr(3'd1, 16'hFC07);
        rd(3'd1, 16'h0007, "R2 upper bits");
        wr(3'd1, 16'h03FF);
        rd(3'd1, 16'h03FF, "R2 max init");
        wr(3'd1, 16'h0006);

        // R4 reload, R5 counting
        wr(3'd0, 16'hBEEF);
        rd(3'd0, 16'h0006, "R4 reload");
        wr(3'd4, 16'h0000);
        rd(3'd4, 16'h0000, "R5 halt cleared");
        ticks(2);
        rd(3'd0, 16'h0004, "R5 two ticks");
        wr(3'd0, 16'h0000);
        rd(3'd0, 16'h0006, "R4 reload again");

        // R6 first expiry
        ticks(7);
        expect_item(SEL_IRQ, 16'h0001, "R6 irq pulse");
        expect_item(SEL_IRQ, 16'h0000, "R6 irq one cycle");
        rd(3'd2, 16'h0008, "R6 stat1 set");
        rd(3'd0, 16'h0006, "R6 auto reload");
        rd(3'd3, 16'h0000, "R6 stat2 clear");

        // R7 write-one-to-clear and restart
        wr(3'd2, 16'h0000);
        rd(3'd2, 16'h0008, "R7 write zero keeps");
        wr(3'd2, 16'h0008);
        rd(3'd2, 16'h0000, "R7 cleared");
        ticks(7);
        expect_item(SEL_IRQ, 16'h0001, "R7 restart first expiry");
        rd(3'd3, 16'h0000, "R7 no second flag");

        // R9 second expiry with veto
        ticks(7);
        expect_item(SEL_IRQ, 16'h0000, "R8 no irq on second");
        expect_item(SEL_RST, 16'h0000, "R9 veto");
        rd(3'd3, 16'h0002, "R9 stat2 still set");

        // R8 second expiry requests reset
        wr(3'd3, 16'h0002);
        rd(3'd3, 16'h0000, "R8 stat2 cleared");
        wr(3'd5, 16'h0000);
        rd(3'd5, 16'h0000, "R9 noreboot off");
        ticks(7);
        expect_item(SEL_RST, 16'h0001, "R8 rst_req");
        rd(3'd3, 16'h0002, "R8 stat2 set");
        wr(3'd3, 16'h0002);
        expect_item(SEL_RST, 16'h0000, "R8 rst_req cleared");

        // R5 halt again
        wr(3'd4, 16'h0800);
        ticks(5);
        rd(3'd0, 16'h0006, "R5 halt again");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule